// File: doc/BRIEF.md
# Programmable-Length CRC Engine with Input Queue

This block computes a cyclic redundancy check over a stream of data words whose width (1 to 16 bits) and generator polynomial are both set by software. Words are written over a simple register-write port into a small queue. A bit serializer then pulls the word at the head of the queue and feeds it into a linear feedback shift register, most significant bit first, at one bit per clock.

A live word count, full and empty flags, and a one-cycle interrupt let software keep the queue topped up while the engine runs. The width setting also selects the queue depth: 16 entries for narrow words and 8 for wide ones. The shift register can be seeded before a run. Its contents, masked to the programmed width, are the CRC result, which is final once the empty flag rises.

A sleep input always freezes the engine. An idle input freezes it only when a control bit allows this.

Top module: `crc_fifo_engine`

## Requirements
- R1: After reset, word_count is 0, fifo_empty is 1, fifo_full is 0, crc_irq is 0 and crc_value is 0.
- R2: Register select wr_addr: 0 is control {bit5 idle-stop, bit4 go, bits3:0 width field W}; 1 is the tap register; 2 is the seed; 3 is data. The data word is W+1 bits wide, and any written bits above bit W are ignored.
- R3: For W<=7 a data word lives in byte lane 0 (wr_be[0], bits 7:0), and a write to that lane adds one word. For W>7, lane 0 alone only stages the low byte and does not change the count. A write that includes lane 1 (wr_be[1], bits 15:8) adds one word, built from the high byte and the staged or same-cycle low byte.
- R4: The queue depth is 16 when W<=7 and 8 when W>7. fifo_full is 1 exactly when word_count equals the depth, and fifo_empty is 1 exactly when word_count is 0.
- R5: A data write while fifo_full is 1 sets word_count to 0 and discards every queued word, including the one just written. The engine then acts as empty, and crc_irq stays 0.
- R6: Bits are shifted only while go is 1 and word_count is nonzero. Each word takes W+1 clocks. word_count drops by one on the clock that shifts the word's last bit, so N queued words drain in N*(W+1) clocks after the go write.
- R7: crc_irq is a one-cycle pulse, high in the cycle right after word_count falls from 1 to 0 through shifting, and at no other time.
- R8: For each data bit d, taken MSB first: f = d XOR state[W]; the new bit k is state[k-1] XOR (tap[k] AND f), and the new bit 0 is tap[0] AND f. crc_value is the state with every bit above W forced to 0.
- R9: A write to the seed register loads the shift register. That value is the starting state of the next run.
- R10: While sleep_req is 1, or idle_req is 1 with idle-stop set, no state changes at all and register writes are ignored. Operation resumes exactly where it stopped. With idle-stop clear, idle_req has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (control, taps, seed, data) |
| wr_be | input | 2 | Byte-lane enables for data writes |
| wr_data | input | 16 | Write data |
| sleep_req | input | 1 | Unconditional suspend |
| idle_req | input | 1 | Suspend when idle-stop is set |
| crc_value | output | 16 | Shift register masked to the programmed width |
| word_count | output | 5 | Number of queued words |
| fifo_full | output | 1 | Queue at its depth |
| fifo_empty | output | 1 | Queue holds no word |
| crc_irq | output | 1 | Pulse when the queue drains to zero |

## Verification
Runs are made with widths of 4, 8, 9 and 16 bits and with several generators and seeds, including the common 16-bit CCITT tap set and an all-ones seed. Each combination exposes a different fault: an off-by-one in the feedback tap index, bit order within a word, or masking of the result. Data words carry junk above the programmed width, so any leak of unused bits shows up as a wrong CRC. Directed runs split a wide word across two lane writes, fill both queue depths and overflow them, and freeze mid-word under sleep and idle. In each case the bench checks that the drain timing and the final CRC match an unfrozen run.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W   = 16;
  localparam int PLEN_W  = 4;
  localparam int DEEP    = 16;
  localparam int SHALLOW = 8;
  localparam int CNT_W   = $clog2(DEEP + 1);
  localparam int PTR_W   = $clog2(DEEP);

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TAPS = 2'd1,
    SEL_SEED = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  // Queue depth for a width setting: wide words halve the depth.
  function automatic logic [CNT_W-1:0] depth_for(input logic [PLEN_W-1:0] plen);
    return (plen > PLEN_W'(7)) ? CNT_W'(SHALLOW) : CNT_W'(DEEP);
  endfunction

  // Ones in bits 0..plen.
  function automatic logic [CRC_W-1:0] width_mask(input logic [PLEN_W-1:0] plen);
    logic [CRC_W-1:0] m;
    m = '0;
    for (int i = 0; i < CRC_W; i++)
      if (i <= int'(plen)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/crc_word_fifo.sv
module crc_word_fifo
  import crc_pkg::*;
#(
  parameter int DATA_W = CRC_W,
  parameter int DEPTH  = DEEP,
  parameter int SMALL  = SHALLOW,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wide,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              wrap_evt,
  output logic              drain_evt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q, depth_w;
  logic              do_pop;

  function automatic logic [PW-1:0] ptr_adv(input logic [PW-1:0] p,
                                            input logic [CW-1:0] d);
    return (p == PW'(d - CW'(1))) ? '0 : p + PW'(1);
  endfunction

  assign depth_w   = wide ? CW'(SMALL) : CW'(DEPTH);
  assign full      = (count_q == depth_w);
  assign empty     = (count_q == '0);
  assign wrap_evt  = push && full && !hold;
  assign do_pop    = pop && !empty && !hold && !wrap_evt;
  assign drain_evt = do_pop && !push && (count_q == CW'(1));
  assign head      = mem[rd_ptr_q];
  assign count     = count_q;

  always_ff @(posedge clk) begin
    if (push && !hold && !full) mem[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (!hold) begin
      if (wrap_evt) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        count_q  <= '0;
      end else begin
        if (push)   wr_ptr_q <= ptr_adv(wr_ptr_q, depth_w);
        if (do_pop) rd_ptr_q <= ptr_adv(rd_ptr_q, depth_w);
        count_q <= count_q + CW'(push) - CW'(do_pop);
      end
    end
  end

  // R5
  wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0) && empty);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_evt) |=> (count == $past(count)) || (count == $past(count) + CW'(1))
                    || (count + CW'(1) == $past(count)));

  // R7
  drain_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt |=> empty);
endmodule

// File: rtl/crc_bit_serializer.sv
module crc_bit_serializer
  import crc_pkg::*;
#(
  parameter int DATA_W = CRC_W,
  parameter int LEN_W  = PLEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              flush,
  input  logic              go,
  input  logic [LEN_W-1:0]  plen,
  input  logic              have_word,
  input  logic [DATA_W-1:0] head,
  output logic              bit_valid,
  output logic              bit_out,
  output logic              word_done
);
  logic [LEN_W-1:0] bit_idx_q;

  assign bit_valid = go && have_word && !hold && !flush;
  assign bit_out   = head[plen - bit_idx_q];
  assign word_done = bit_valid && (bit_idx_q == plen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bit_idx_q <= '0;
    else if (flush && !hold)   bit_idx_q <= '0;
    else if (bit_valid)        bit_idx_q <= word_done ? '0 : bit_idx_q + LEN_W'(1);
  end

  // R6
  no_go_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go || hold) |=> $stable(bit_idx_q) || $past(flush));
endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
  import crc_pkg::*;
#(
  parameter int WIDTH = CRC_W,
  parameter int LEN_W = PLEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             seed_wr,
  input  logic [WIDTH-1:0] seed,
  input  logic             bit_valid,
  input  logic             din,
  input  logic [WIDTH-1:0] taps,
  input  logic [LEN_W-1:0] plen,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] state_q, nxt;
  logic             fb;

  assign fb = din ^ state_q[plen];

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_tap
      if (k == 0) begin : g_lsb
        assign nxt[k] = taps[k] & fb;
      end else begin : g_mid
        assign nxt[k] = state_q[k-1] ^ (taps[k] & fb);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 state_q <= '0;
    else if (seed_wr && !hold)  state_q <= seed;
    else if (bit_valid)         state_q <= nxt;
  end

  assign state = state_q;

  // R8
  lfsr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !(seed_wr && !hold)) |=> $stable(state));
endmodule

// File: rtl/crc_fifo_engine.sv
module crc_fifo_engine
  import crc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [1:0]          wr_be,
  input  logic [CRC_W-1:0]    wr_data,
  input  logic                sleep_req,
  input  logic                idle_req,
  output logic [CRC_W-1:0]    crc_value,
  output logic [CNT_W-1:0]    word_count,
  output logic                fifo_full,
  output logic                fifo_empty,
  output logic                crc_irq
);
  localparam int HALF = CRC_W / 2;

  logic [PLEN_W-1:0] plen_q;
  logic              go_q, idle_stop_q, irq_q;
  logic [CRC_W-1:0]  taps_q;
  logic [HALF-1:0]   lo_hold_q;

  logic              susp, wr_ok, wide, data_wr, push, seed_wr;
  logic [CRC_W-1:0]  push_word, head, lfsr_state;
  logic              wrap_evt, drain_evt, bit_valid, bit_out, word_done;

  assign susp    = sleep_req || (idle_req && idle_stop_q);
  assign wr_ok   = wr_en && !susp;
  assign wide    = plen_q > PLEN_W'(7);
  assign data_wr = wr_ok && (wr_addr == SEL_DATA);
  assign seed_wr = wr_ok && (wr_addr == SEL_SEED);
  assign push    = data_wr && (wide ? wr_be[1] : wr_be[0]);

  always_comb begin
    if (wide)
      push_word = {wr_data[CRC_W-1:HALF], wr_be[0] ? wr_data[HALF-1:0] : lo_hold_q};
    else
      push_word = {{HALF{1'b0}}, wr_data[HALF-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plen_q      <= '0;
      go_q        <= 1'b0;
      idle_stop_q <= 1'b0;
      taps_q      <= '0;
      lo_hold_q   <= '0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= drain_evt && !susp;
      if (wr_ok && wr_addr == SEL_CTRL) begin
        plen_q      <= wr_data[PLEN_W-1:0];
        go_q        <= wr_data[PLEN_W];
        idle_stop_q <= wr_data[PLEN_W+1];
      end
      if (wr_ok && wr_addr == SEL_TAPS) taps_q <= wr_data;
      if (data_wr && wr_be[0])          lo_hold_q <= wr_data[HALF-1:0];
    end
  end

  crc_word_fifo #(.DATA_W(CRC_W), .DEPTH(DEEP), .SMALL(SHALLOW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (susp),
    .wide      (wide),
    .push      (push),
    .push_data (push_word),
    .pop       (word_done),
    .head      (head),
    .count     (word_count),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .wrap_evt  (wrap_evt),
    .drain_evt (drain_evt)
  );

  crc_bit_serializer #(.DATA_W(CRC_W), .LEN_W(PLEN_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (susp),
    .flush     (wrap_evt),
    .go        (go_q),
    .plen      (plen_q),
    .have_word (!fifo_empty),
    .head      (head),
    .bit_valid (bit_valid),
    .bit_out   (bit_out),
    .word_done (word_done)
  );

  crc_lfsr_core #(.WIDTH(CRC_W), .LEN_W(PLEN_W)) u_lfsr (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (susp),
    .seed_wr   (seed_wr),
    .seed      (wr_data),
    .bit_valid (bit_valid),
    .din       (bit_out),
    .taps      (taps_q),
    .plen      (plen_q),
    .state     (lfsr_state)
  );

  assign crc_value = lfsr_state & width_mask(plen_q);
  assign crc_irq   = irq_q;

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_irq |-> (word_count == '0) && ($past(word_count) == CNT_W'(1)));

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> $stable(word_count) && $stable(crc_value) && $stable(go_q));

  // R5
  wrap_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !crc_irq);

  // R4
  full_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (word_count == depth_for(plen_q)));
endmodule

// File: tb/sim_crc_fifo_engine.sv
`timescale 1ns/1ps
module sim_crc_fifo_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic        sleep_req = 1'b0;
  logic        idle_req = 1'b0;
  logic [15:0] crc_value;
  logic [4:0]  word_count;
  logic        fifo_full, fifo_empty, crc_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  crc_fifo_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .sleep_req(sleep_req), .idle_req(idle_req),
    .crc_value(crc_value), .word_count(word_count), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .crc_irq(crc_irq)
  );

  // {width field, taps, seed, word0, word1, word2}
  localparam logic [83:0] VEC [5] = '{
    {4'd15, 16'h1021, 16'h0000, 16'h3132, 16'h3334, 16'h3536},
    {4'd15, 16'h8005, 16'hFFFF, 16'hABCD, 16'h0000, 16'hFFFF},
    {4'd7,  16'h0007, 16'h0000, 16'hEE12, 16'h7734, 16'h00C9},
    {4'd3,  16'h0003, 16'h0000, 16'h00F5, 16'h00A2, 16'h003C},
    {4'd8,  16'h0131, 16'h00AA, 16'h01FF, 16'hFE01, 16'h0123}
  };

  function automatic logic [15:0] model(input logic [3:0] w, input logic [15:0] taps,
                                        input logic [15:0] seed, input logic [15:0] d0,
                                        input logic [15:0] d1, input logic [15:0] d2,
                                        input int n);
    logic [15:0] c, m, dw;
    m = 16'((32'd1 << (w + 1)) - 1);
    c = seed & m;
    for (int i = 0; i < n; i++) begin
      dw = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      for (int b = 15; b >= 0; b--) begin
        if (b <= int'(w)) begin
          logic top;
          top = c[w];
          c = c << 1;
          if (dw[b] ^ top) c = c ^ taps;
          c = c & m;
        end
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic ctrl(input logic [3:0] w, input bit go, input bit istop);
    reg_wr(2'd0, 2'b11, {10'd0, istop, go, w});
  endtask

  task automatic put(input logic [3:0] w, input logic [15:0] d);
    reg_wr(2'd3, (w > 4'd7) ? 2'b11 : 2'b01, d);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(word_count == 0 && fifo_empty && !fifo_full && !crc_irq && crc_value == 0,
        "R1", {word_count, fifo_empty, fifo_full, crc_irq}, 5'd0 << 3 | 4);
    rst_n = 1'b1;
    @(negedge clk);

    // Table runs: R2 R6 R7 R8 R9
    for (int v = 0; v < 5; v++) begin
      logic [3:0] w; logic [15:0] tp, sd, d0, d1, d2;
      int len;
      {w, tp, sd, d0, d1, d2} = VEC[v];
      len = 3 * (int'(w) + 1);
      ctrl(w, 1'b0, 1'b0);
      reg_wr(2'd1, 2'b11, tp);
      reg_wr(2'd2, 2'b11, sd);
      chk(crc_value == (sd & 16'((32'd1 << (w + 1)) - 1)), "R9", crc_value, sd);
      put(w, d0); put(w, d1); put(w, d2);
      chk(word_count == 3, "R3", word_count, 3);
      ctrl(w, 1'b1, 1'b0);
      repeat (len - 1) @(negedge clk);
      chk(word_count == 1 && !crc_irq, "R6", word_count, 1);
      @(negedge clk);
      chk(word_count == 0 && fifo_empty, "R6", word_count, 0);
      chk(crc_irq == 1'b1, "R7", crc_irq, 1);
      exp = model(w, tp, sd, d0, d1, d2, 3);
      chk(crc_value == exp, "R8 R2", crc_value, exp);
      @(negedge clk);
      chk(crc_irq == 1'b0, "R7", crc_irq, 0);
      ctrl(w, 1'b0, 1'b0);
    end

    // R3 split wide word
    ctrl(4'd15, 1'b0, 1'b0);
    reg_wr(2'd1, 2'b11, 16'h1021);
    reg_wr(2'd2, 2'b11, 16'h0000);
    reg_wr(2'd3, 2'b01, 16'h0056);
    chk(word_count == 0, "R3", word_count, 0);
    reg_wr(2'd3, 2'b10, 16'h7800);
    chk(word_count == 1, "R3", word_count, 1);
    // R6 no shift with go clear
    repeat (10) @(negedge clk);
    chk(word_count == 1 && crc_value == 0, "R6", crc_value, 0);
    ctrl(4'd15, 1'b1, 1'b0);
    repeat (16) @(negedge clk);
    exp = model(4'd15, 16'h1021, 16'h0, 16'h7856, 16'h0, 16'h0, 1);
    chk(crc_value == exp && fifo_empty, "R3", crc_value, exp);
    ctrl(4'd7, 1'b0, 1'b0);

    // R4 depth 16, R5 wrap
    reg_wr(2'd2, 2'b11, 16'h005A);
    for (int i = 0; i < 15; i++) put(4'd7, 16'(i));
    chk(!fifo_full && word_count == 15, "R4", word_count, 15);
    put(4'd7, 16'h00AA);
    chk(fifo_full && word_count == 16, "R4", word_count, 16);
    put(4'd7, 16'h00BB);
    chk(word_count == 0 && fifo_empty && !crc_irq, "R5", word_count, 0);
    ctrl(4'd7, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk(crc_value == 16'h005A && !crc_irq, "R5", crc_value, 16'h005A);
    // R4 depth 8
    ctrl(4'd8, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) put(4'd8, 16'(i));
    chk(!fifo_full, "R4", fifo_full, 0);
    put(4'd8, 16'h0100);
    chk(fifo_full && word_count == 8, "R4", word_count, 8);
    put(4'd8, 16'h0101);
    chk(word_count == 0 && !fifo_full && !crc_irq, "R5", word_count, 0);

    // R10 suspend
    ctrl(4'd3, 1'b0, 1'b1);
    reg_wr(2'd1, 2'b11, 16'h0003);
    reg_wr(2'd2, 2'b11, 16'h0000);
    put(4'd3, 16'h0009); put(4'd3, 16'h0006);
    ctrl(4'd3, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    begin
      logic [15:0] cv; logic [4:0] wc;
      cv = crc_value; wc = word_count;
      sleep_req = 1'b1;
      put(4'd3, 16'h000F);
      repeat (5) @(negedge clk);
      chk(crc_value == cv && word_count == wc, "R10", crc_value, cv);
      sleep_req = 1'b0;
      idle_req = 1'b1;
      repeat (4) @(negedge clk);
      chk(crc_value == cv && word_count == wc, "R10", word_count, wc);
      idle_req = 1'b0;
    end
    repeat (5) @(negedge clk);
    chk(word_count == 1, "R10", word_count, 1);
    @(negedge clk);
    exp = model(4'd3, 16'h0003, 16'h0, 16'h9, 16'h6, 16'h0, 2);
    chk(word_count == 0 && crc_value == exp, "R10", crc_value, exp);
    // idle without idle-stop has no effect
    ctrl(4'd3, 1'b0, 1'b0);
    reg_wr(2'd2, 2'b11, 16'h0000);
    put(4'd3, 16'h0009); put(4'd3, 16'h0006);
    idle_req = 1'b1;
    ctrl(4'd3, 1'b1, 1'b0);
    repeat (8) @(negedge clk);
    chk(word_count == 0 && crc_value == exp, "R10", crc_value, exp);
    idle_req = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule